// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits behind the register port of a multi-queue storage controller and handles the doorbell part of the register space. Host software rings a doorbell by writing to it. A submission doorbell reports a new tail for a submission queue. A completion doorbell reports a new head for a completion queue. The block checks each write. It keeps one tail pointer per submission queue and one head pointer per completion queue, and emits one-cycle wake-up pulses for the command fetch logic and for the completion poster.

The doorbell window starts at byte offset 0x1000. The two kinds of doorbell alternate at a 4-byte stride, so each queue pair owns 8 bytes. Writes that cannot be served are dropped without any response. This covers a misaligned address, an address below the window, an unknown queue, and a pointer value outside the queue.

A completion head write can free a queue that was full. In that case the block wakes the completion poster and restarts every created submission queue that is bound to that completion queue. If, after the head moves, completions are still waiting (the tail is not equal to the new head), the block asks for the interrupt of that queue to be raised again.

Top module: `qdb_decoder`

## Requirements
- R1: After a synchronous reset every submission tail and every completion head reads 0, and no wake-up or interrupt pulse is high.
- R2: A strobed write to 0x1000 + 8·q, where q is a created submission queue, stores the value in that queue's tail. In the cycle after the strobe, sq_kick bit q is high and no other sq_kick bit is high.
- R3: A strobed write to 0x1004 + 8·q, where q is a created completion queue, stores the value in that queue's head and leaves every submission tail unchanged.
- R4: A write is ignored if its address has bit 1 or bit 0 set, or if the address is below 0x1000. Ignored means no pointer changes and no pulse is produced.
- R5: A write is ignored if the queue id is NUM_Q or larger, or if the valid flag for that queue of the addressed kind is low.
- R6: A write is ignored if its 16-bit value is equal to or greater than the size of the addressed queue.
- R7: A completion queue counts as full when (tail + 1) modulo size equals the old head. A valid head write to a full completion queue q raises cq_kick bit q. In the same cycle it raises sq_kick for every created submission queue whose bound completion id is q. This applies across the wrap, for example tail = size − 1 with head = 0.
- R8: After a valid head write to completion queue q, irq_req bit q is high for one cycle exactly when that queue's completion tail differs from the new head.
- R9: All wake-up and interrupt outputs are single-cycle pulses. They are high only in the cycle after a strobed write and drop in the next cycle when no further write follows.
- R10: Bits 31 to 16 of the write data are ignored. Only bits 15 to 0 form the pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; low PTR_W bits used |
| sq_valid | input | NUM_Q | Submission queue created flags |
| cq_valid | input | NUM_Q | Completion queue created flags |
| sq_size | input | NUM_Q·PTR_W | Entry count of each submission queue |
| cq_size | input | NUM_Q·PTR_W | Entry count of each completion queue |
| sq_bind | input | NUM_Q·QID_W | Completion queue id bound to each submission queue |
| cq_tail | input | NUM_Q·PTR_W | Current completion tail from the poster |
| sq_tail | output | NUM_Q·PTR_W | Stored submission tails |
| cq_head | output | NUM_Q·PTR_W | Stored completion heads |
| sq_kick | output | NUM_Q | Fetch wake-up pulse per submission queue |
| cq_kick | output | NUM_Q | Completion poster wake-up pulse per queue |
| irq_req | output | NUM_Q | Interrupt re-raise request per completion queue |

## Verification
A single completion head write can release a full queue and also leave completions pending. In that case the poster wake-up with its fan-out of submission restarts, and the interrupt re-raise, fall in the same cycle. The bench provokes this by setting a completion tail to one slot behind the stored head and then writing a head that differs from that tail. It expects cq_kick, two submission kicks for the two bound queues, and irq_req, all together in the cycle after the strobe. A second case uses the wrap boundary: the new head equals the tail, so the release pulses must appear without an interrupt.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int unsigned DB_BASE      = 32'h1000;
  localparam int unsigned KIND_BIT     = 2;
  localparam int unsigned PAIR_SHIFT   = 3;
  localparam int unsigned DATA_W       = 32;

  typedef enum logic {
    DB_SQ_TAIL = 1'b0,
    DB_CQ_HEAD = 1'b1
  } db_kind_e;
endpackage

// File: rtl/qdb_addr_decode.sv
module qdb_addr_decode
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 64,
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_Q-1:0]       sq_valid,
  input  logic [NUM_Q-1:0]       cq_valid,
  input  logic [NUM_Q*PTR_W-1:0] sq_size,
  input  logic [NUM_Q*PTR_W-1:0] cq_size,
  output logic                   sq_we,
  output logic                   cq_we,
  output logic [QID_W-1:0]       qid,
  output logic [PTR_W-1:0]       val
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] id_full;
  logic              in_win, aligned, id_ok, fits;
  db_kind_e          kind;
  logic [PTR_W-1:0]  lim;

  always_comb begin
    off     = wr_addr - BASE;
    in_win  = (wr_addr >= BASE);
    aligned = (wr_addr[1:0] == 2'b00);
    kind    = db_kind_e'(off[KIND_BIT]);
    id_full = off >> PAIR_SHIFT;
    id_ok   = (id_full < ADDR_W'(NUM_Q));
    qid     = id_full[QID_W-1:0];
    val     = wr_data[PTR_W-1:0];
    lim     = '0;
    if (id_ok) begin
      lim = (kind == DB_SQ_TAIL) ? sq_size[qid*PTR_W +: PTR_W]
                                 : cq_size[qid*PTR_W +: PTR_W];
    end
    fits  = (val < lim);
    sq_we = wr_en && in_win && aligned && id_ok && fits &&
            (kind == DB_SQ_TAIL) && sq_valid[qid];
    cq_we = wr_en && in_win && aligned && id_ok && fits &&
            (kind == DB_CQ_HEAD) && cq_valid[qid];
  end
endmodule

// File: rtl/qdb_ptr_bank.sv
module qdb_ptr_bank #(
  parameter int NUM_Q  = 64,
  parameter int PTR_W  = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [QID_W-1:0]       idx,
  input  logic [PTR_W-1:0]       wdata,
  input  logic [NUM_Q*PTR_W-1:0] size,
  output logic [NUM_Q*PTR_W-1:0] ptr
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr[i*PTR_W +: PTR_W] <= '0;
      end else if (we && (idx == QID_W'(i))) begin
        ptr[i*PTR_W +: PTR_W] <= wdata;
      end
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |=> (ptr[$past(idx)*PTR_W +: PTR_W] < $past(size[idx*PTR_W +: PTR_W]))); // R6
endmodule

// File: rtl/qdb_wake_gen.sv
module qdb_wake_gen #(
  parameter int NUM_Q  = 64,
  parameter int PTR_W  = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   sq_we,
  input  logic                   cq_we,
  input  logic [QID_W-1:0]       qid,
  input  logic [PTR_W-1:0]       val,
  input  logic [NUM_Q*PTR_W-1:0] cq_head_old,
  input  logic [NUM_Q*PTR_W-1:0] cq_tail,
  input  logic [NUM_Q*PTR_W-1:0] cq_size,
  input  logic [NUM_Q-1:0]       sq_valid,
  input  logic [NUM_Q*QID_W-1:0] sq_bind,
  output logic [NUM_Q-1:0]       sq_kick,
  output logic [NUM_Q-1:0]       cq_kick,
  output logic [NUM_Q-1:0]       irq_req
);
  logic [PTR_W-1:0] t_sel, h_sel, s_sel;
  logic [PTR_W:0]   t_inc;
  logic [PTR_W-1:0] t_nxt;
  logic             was_full, release_q;
  logic [NUM_Q-1:0] sq_kick_d, cq_kick_d, irq_d;

  always_comb begin
    t_sel     = cq_tail[qid*PTR_W +: PTR_W];
    h_sel     = cq_head_old[qid*PTR_W +: PTR_W];
    s_sel     = cq_size[qid*PTR_W +: PTR_W];
    t_inc     = {1'b0, t_sel} + 1'b1;
    t_nxt     = (t_inc == {1'b0, s_sel}) ? '0 : t_inc[PTR_W-1:0];
    was_full  = (t_nxt == h_sel);
    release_q = cq_we && was_full;
  end

  for (genvar j = 0; j < NUM_Q; j++) begin : g_q
    always_comb begin
      sq_kick_d[j] = (sq_we && (qid == QID_W'(j))) ||
                     (release_q && sq_valid[j] &&
                      (sq_bind[j*QID_W +: QID_W] == qid));
      cq_kick_d[j] = release_q && (qid == QID_W'(j));
      irq_d[j]     = cq_we && (qid == QID_W'(j)) && (t_sel != val);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_kick <= '0;
      cq_kick <= '0;
      irq_req <= '0;
    end else begin
      sq_kick <= sq_kick_d;
      cq_kick <= cq_kick_d;
      irq_req <= irq_d;
    end
  end

  AST_KICK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|sq_kick || |cq_kick || |irq_req) |-> $past(wr_en)); // R9
  AST_POSTER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cq_kick)); // R7
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_req)); // R8
  AST_SQ_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sq_we |=> ($countones(sq_kick) == 1)); // R2
endmodule

// File: rtl/qdb_decoder.sv
module qdb_decoder
  import qdb_pkg::*;
#(
  parameter int NUM_Q  = 64,
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_Q-1:0]       sq_valid,
  input  logic [NUM_Q-1:0]       cq_valid,
  input  logic [NUM_Q*PTR_W-1:0] sq_size,
  input  logic [NUM_Q*PTR_W-1:0] cq_size,
  input  logic [NUM_Q*QID_W-1:0] sq_bind,
  input  logic [NUM_Q*PTR_W-1:0] cq_tail,
  output logic [NUM_Q*PTR_W-1:0] sq_tail,
  output logic [NUM_Q*PTR_W-1:0] cq_head,
  output logic [NUM_Q-1:0]       sq_kick,
  output logic [NUM_Q-1:0]       cq_kick,
  output logic [NUM_Q-1:0]       irq_req
);
  logic             sq_we, cq_we;
  logic [QID_W-1:0] qid;
  logic [PTR_W-1:0] val;

  qdb_addr_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_valid(sq_valid), .cq_valid(cq_valid),
    .sq_size(sq_size), .cq_size(cq_size),
    .sq_we(sq_we), .cq_we(cq_we), .qid(qid), .val(val)
  );

  qdb_ptr_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_sq_tails (
    .clk(clk), .rst(rst), .we(sq_we), .idx(qid), .wdata(val),
    .size(sq_size), .ptr(sq_tail)
  );

  qdb_ptr_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_cq_heads (
    .clk(clk), .rst(rst), .we(cq_we), .idx(qid), .wdata(val),
    .size(cq_size), .ptr(cq_head)
  );

  qdb_wake_gen #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_wake (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sq_we(sq_we), .cq_we(cq_we),
    .qid(qid), .val(val), .cq_head_old(cq_head), .cq_tail(cq_tail),
    .cq_size(cq_size), .sq_valid(sq_valid), .sq_bind(sq_bind),
    .sq_kick(sq_kick), .cq_kick(cq_kick), .irq_req(irq_req)
  );

  AST_QUIET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(sq_tail) && $stable(cq_head))); // R4
  AST_HEAD_WRITE_KEEPS_TAILS: assert property (@(posedge clk) disable iff (rst)
    cq_we |=> $stable(sq_tail)); // R3
endmodule

// File: tb/sim_qdb_decoder.sv
module sim_qdb_decoder;
  localparam int NQ = 64;
  localparam int AW = 16;
  localparam int PW = 16;
  localparam int QW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NQ-1:0] sq_valid, cq_valid;
  logic [NQ*PW-1:0] sq_size, cq_size, cq_tail;
  logic [NQ*QW-1:0] sq_bind;
  logic [NQ*PW-1:0] sq_tail, cq_head;
  logic [NQ-1:0] sq_kick, cq_kick, irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qdb_decoder #(.NUM_Q(NQ), .ADDR_W(AW), .PTR_W(PW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_valid(sq_valid), .cq_valid(cq_valid), .sq_size(sq_size),
    .cq_size(cq_size), .sq_bind(sq_bind), .cq_tail(cq_tail),
    .sq_tail(sq_tail), .cq_head(cq_head), .sq_kick(sq_kick),
    .cq_kick(cq_kick), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sqt(input int q); return 64'(sq_tail[q*PW +: PW]); endfunction
  function automatic logic [63:0] cqh(input int q); return 64'(cq_head[q*PW +: PW]); endfunction

  // Drive one strobed write; returns at the negedge after the capturing edge.
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses_gone(input string req);
    @(negedge clk);
    chk(req, {sq_kick | cq_kick | irq_req}, 64'd0);
  endtask

  task automatic t_reset();
    for (int q = 0; q < NQ; q++) begin
      chk("R1 sq_tail", sqt(q), 64'd0);
      chk("R1 cq_head", cqh(q), 64'd0);
    end
    chk("R1 pulses", {sq_kick | cq_kick | irq_req}, 64'd0);
  endtask

  task automatic t_sq_write();
    wr(16'h1000 + 16'd16, 32'hABCD_0005);
    chk("R2 tail q2", sqt(2), 64'd5);
    chk("R10 upper bits", sqt(2), 64'h0005);
    chk("R2 kick", 64'(sq_kick), 64'h4);
    chk("R2 no poster", 64'(cq_kick), 64'd0);
    pulses_gone("R9 drop");
  endtask

  task automatic t_sq_bounds();
    wr(16'h1008, 32'd7);
    chk("R6 size-1 accepted", sqt(1), 64'd7);
    wr(16'h1008, 32'd8);
    chk("R6 size rejected", sqt(1), 64'd7);
    chk("R6 no kick", 64'(sq_kick), 64'd0);
  endtask

  task automatic t_ignored();
    wr(16'h1002, 32'd3);
    chk("R4 misaligned", sqt(0), 64'd0);
    chk("R4 no kick", 64'(sq_kick), 64'd0);
    wr(16'h0FF8, 32'd3);
    chk("R4 below window tail", sqt(0), 64'd0);
    chk("R4 below window kick", 64'(sq_kick | cq_kick), 64'd0);
    wr(16'h1000 + 16'd80, 32'd2);
    chk("R5 uncreated sq", sqt(10), 64'd0);
    chk("R5 uncreated kick", 64'(sq_kick), 64'd0);
    wr(16'h1000 + 16'd512, 32'd2);
    chk("R5 id beyond NUM_Q", 64'(sq_kick | cq_kick | irq_req), 64'd0);
    chk("R5 id beyond tails q0", sqt(0), 64'd0);
    wr(16'h1004 + 16'd40, 32'd1);
    chk("R5 uncreated cq", cqh(5), 64'd0);
    wr(16'h1004, 32'd4);
    chk("R6 cq head at size", cqh(0), 64'd0);
    chk("R6 cq no irq", 64'(irq_req), 64'd0);
  endtask

  task automatic t_cq_head();
    cq_tail[1*PW +: PW] = 16'd2;
    wr(16'h100C, 32'd1);
    chk("R3 head q1", cqh(1), 64'd1);
    chk("R3 tails kept", sqt(1), 64'd7);
    chk("R3 no fetch kick", 64'(sq_kick | cq_kick), 64'd0);
    chk("R8 irq pending", 64'(irq_req), 64'h2);
    wr(16'h100C, 32'd2);
    chk("R8 no irq when drained", 64'(irq_req), 64'd0);
  endtask

  task automatic t_full_release();
    // head=2, tail=1, size 4: (1+1)%4==2 -> full
    cq_tail[1*PW +: PW] = 16'd1;
    wr(16'h100C, 32'd3);
    chk("R7 poster wake", 64'(cq_kick), 64'h2);
    chk("R7 bound sqs restarted", 64'(sq_kick), 64'h6);
    chk("R8 irq with release", 64'(irq_req), 64'h2);
    pulses_gone("R9 drop after release");
    // wrap: cq2 head 0, tail 3, size 4 -> full
    cq_tail[2*PW +: PW] = 16'd3;
    wr(16'h1014, 32'd3);
    chk("R7 wrap poster", 64'(cq_kick), 64'h4);
    chk("R7 wrap sq3", 64'(sq_kick), 64'h8);
    chk("R8 wrap no irq", 64'(irq_req), 64'd0);
    chk("R3 wrap head", cqh(2), 64'd3);
  endtask

  initial begin
    sq_valid = 64'hF;
    cq_valid = 64'h7;
    sq_size = '0; cq_size = '0; cq_tail = '0; sq_bind = '0;
    for (int q = 0; q < NQ; q++) begin
      sq_size[q*PW +: PW] = 16'd8;
      cq_size[q*PW +: PW] = 16'd4;
    end
    sq_bind[1*QW +: QW] = 6'd1;
    sq_bind[2*QW +: QW] = 6'd1;
    sq_bind[3*QW +: QW] = 6'd2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sq_write();
    t_sq_bounds();
    t_ignored();
    t_cq_head();
    t_full_release();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule